// File: doc/BRIEF.md
# Restoring Shift-Subtract Divider

This block divides an unsigned dividend of twice the quotient width by an unsigned divisor of the quotient width. With the defaults, an 8-bit dividend is divided by a 4-bit divisor. It uses the restoring shift-subtract method inside one working register that is one bit wider than the dividend. A carry-style compare tells whether the divisor fits under the top bits of that register. When it fits, the block subtracts and writes a 1 into the lowest bit. Otherwise the register moves left by one place. After the last step, the quotient sits in the lowest bits and the remainder in the bits just above them.

Before any quotient bit is produced, the block tests whether the quotient can fit in its width at all. If it cannot, the block raises an overflow flag and goes back to idle without dividing. A divisor of zero always takes this path. The caller waits for `ready`, presents the operands, and pulses `start`. It then waits for `ready` to return and reads `quotient`, `remainder` and `overflow`.

Top module: `shift_sub_divider`

## Requirements
- R1: After reset, `ready` is 1, `overflow` is 0, and `quotient` and `remainder` are 0. `ready` is 1 exactly while the block is idle.
- R2: When `start` is 1 while `ready` is 1, the block captures `dividend` and `divisor` on that clock edge, and `ready` is 0 from the next cycle on.
- R3: When `dividend >= divisor * 16`, the block reports overflow. This always includes `divisor == 0`. `overflow` becomes 1, and `ready` returns after exactly one busy cycle.
- R4: Without overflow, on completion `quotient` equals `dividend / divisor` (read from register bits 3..0). `remainder` equals `dividend % divisor` (read from register bits 7..4).
- R5: Each accepted start clears `overflow`. Otherwise `overflow` holds its value while idle, until the next start.
- R6: Without overflow, the busy time is 5 cycles plus the number of 1 bits among quotient bits 3, 2 and 1. Each of those digits costs one extra subtract cycle. The lowest digit's subtract shares the final cycle.
- R7: While the block is busy, `start` and changes on `dividend` and `divisor` have no effect on the result.
- R8: Dividing 135 by 13 gives quotient 10 and remainder 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division (accepted only while ready) |
| dividend | input | 8 | Unsigned dividend |
| divisor | input | 4 | Unsigned divisor |
| quotient | output | 4 | Quotient digits, valid when ready after a run |
| remainder | output | 4 | Remainder, valid when ready after a run |
| overflow | output | 1 | Quotient would not fit, or divisor is zero |
| ready | output | 1 | Block is idle and accepts start |

## Verification
All 4096 pairs of dividend and divisor are applied. This sweep covers both sides of the overflow boundary, including a zero divisor, dividends just below and at sixteen times the divisor, and zero and full-scale dividends. The count of busy cycles from every run is compared with the count predicted from the quotient bits. This exposes extra or missing subtract and shift steps that could still leave a correct quotient. On a regular subset of runs, `start` is held high and the operands are changed throughout the busy period. This shows that nothing is re-sampled during a division.

// File: rtl/shift_sub_divider.sv
module shift_sub_divider #(
  parameter int QW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2*QW-1:0] dividend,
  input  logic [QW-1:0]   divisor,
  output logic [QW-1:0]   quotient,
  output logic [QW-1:0]   remainder,
  output logic            overflow,
  output logic            ready
);
  localparam int DW = 2 * QW;
  localparam int XW = DW + 1;
  localparam int CW = $clog2(QW + 1);
  localparam logic [CW-1:0] LAST = CW'(QW - 1);

  typedef enum logic [1:0] {S_IDLE, S_CHK, S_RUN, S_END} st_t;

  st_t            st;
  logic [XW-1:0]  x;
  logic [QW-1:0]  dsr;
  logic [CW-1:0]  nshift;
  logic [QW:0]    upper;
  logic [QW:0]    diff;
  logic           c;

  assign upper     = x[XW-1:QW];
  assign c         = upper >= {1'b0, dsr};
  assign diff      = upper - {1'b0, dsr};
  assign quotient  = x[QW-1:0];
  assign remainder = x[DW-1:QW];
  assign ready     = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      x        <= '0;
      dsr      <= '0;
      nshift   <= '0;
      overflow <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          x        <= {1'b0, dividend};
          dsr      <= divisor;
          overflow <= 1'b0;
          nshift   <= '0;
          st       <= S_CHK;
        end
        S_CHK: begin
          if (c) begin
            overflow <= 1'b1;
            st       <= S_IDLE;
          end else begin
            x      <= {x[XW-2:0], 1'b0};
            nshift <= nshift + 1'b1;
            st     <= S_RUN;
          end
        end
        S_RUN: begin
          if (c) begin
            x <= {diff, x[QW-1:1], 1'b1};
          end else begin
            x      <= {x[XW-2:0], 1'b0};
            nshift <= nshift + 1'b1;
            if (nshift == LAST) st <= S_END;
          end
        end
        S_END: begin
          if (c) x <= {diff, x[QW-1:1], 1'b1};
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2: an accepted start makes the block busy on the next cycle
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready && start |=> !ready);

  // R3: a fitting divisor right after load means overflow and an immediate return
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHK) && c |=> ready && overflow);

  // R4: a finished division leaves a remainder below the divisor
  assert_rem_small_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) && !overflow |-> remainder < dsr);

  // R5: each accepted start clears the flag
  assert_ovf_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ready && start |=> !overflow);

  // R5: the flag holds while idle without a start
  assert_ovf_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !start |=> $stable(overflow));

  // R7: the captured divisor stays put while busy
  assert_dsr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(dsr));

  // R6: never more shifts than quotient digits
  assert_shift_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nshift <= CW'(QW));
endmodule

// File: tb/shift_sub_divider_tb.sv
module shift_sub_divider_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] dividend = '0;
  logic [3:0] divisor = '0;
  logic [3:0] quotient, remainder;
  logic       overflow, ready;
  int         n_run = 0;
  int         n_fail = 0;
  int         cyc = 0;

  always #5 clk = ~clk;

  shift_sub_divider #(.QW(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .quotient(quotient), .remainder(remainder),
    .overflow(overflow), .ready(ready)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_run = n_run + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic divide(input int dd, input int dv, input bit disturb);
    int busy;
    int eq, er, ov, pc;
    ov = (dd >= dv * 16) ? 1 : 0;
    eq = ov ? 0 : dd / dv;
    er = ov ? 0 : dd % dv;
    pc = ((eq >> 3) & 1) + ((eq >> 2) & 1) + ((eq >> 1) & 1);
    @(negedge clk);
    dividend = 8'(dd);
    divisor  = 4'(dv);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 ready low after start", int'(ready), 0);
    check("R5 overflow cleared at start", int'(overflow), 0);
    busy = 0;
    while (!ready && busy < 40) begin
      busy = busy + 1;
      if (disturb) begin
        start    = 1'b1;
        dividend = ~dividend;
        divisor  = divisor + 4'd5;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check("R3 overflow flag", int'(overflow), ov);
    if (ov) begin
      check("R3 busy cycles on overflow", busy, 1);
    end else begin
      check(disturb ? "R7 quotient under disturbance" : "R4 quotient", int'(quotient), eq);
      check(disturb ? "R7 remainder under disturbance" : "R4 remainder", int'(remainder), er);
      check("R6 busy cycles", busy, 5 + pc);
    end
    @(negedge clk);
    check("R5 overflow held while idle", int'(overflow), ov);
    check("R1 ready while idle", int'(ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset ready", int'(ready), 1);
    check("R1 reset overflow", int'(overflow), 0);
    check("R1 reset quotient", int'(quotient), 0);
    check("R1 reset remainder", int'(remainder), 0);
    rst_n = 1'b1;
    @(negedge clk);
    divide(135, 13, 1'b0);
    check("R8 quotient of 135/13", int'(quotient), 10);
    check("R8 remainder of 135/13", int'(remainder), 5);
    for (int dv = 0; dv < 16; dv++) begin
      for (int dd = 0; dd < 256; dd++) begin
        divide(dd, dv, ((dd + dv) % 7) == 0);
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule